// File: doc/BRIEF.md
# Dual-Channel Buck Start-Up and Fault Supervisor

This block sits beside two synchronous buck regulators and decides, once per switching cycle, whether each channel may switch. It works from a global active-low shutdown input and a per-channel pair of ramp comparator flags. One flag says the soft-start ramp has passed its enable level and the other says it has passed its full-run level. From these it decides, per channel, whether the channel is off, ramping or running. Comparator flags from the analog side report output overvoltage, output below 20 % and below 93 % of nominal, and a current-limit hit in the current cycle.

Two protection latches are shared by both channels. An overvoltage on either output latches both channels off, with the high-side switch forced off and the low-side switch forced on to pull the outputs down. A run of current-limit hits while an output has collapsed latches both channels off, with only the high side forced off. A latch is released by a low-then-high sequence on the shutdown input or on any ramp-enable flag, or by the input-supply dip flag. The block takes one clock per switching cycle. The three control inputs pass through a synchronizer, while the fault flags are already synchronous.

Top module: `conv_supervisor`

## Requirements
- R1: With `shdn_n` low (after the synchronizer), every channel has `chan_en`=0, `chan_soft`=0, `hs_off`=1 and `ls_on`=0, whatever the ramp flags and the 93 % flags are.
- R2: With `shdn_n` high, no bias fault and no latched fault, a channel with `ramp_lo`=0 is off. With `ramp_lo`=1 and `ramp_hi`=0 it is enabled with `chan_soft`=1. With both flags at 1 it is enabled with `chan_soft`=0. A change on a control input reaches the outputs after `SYNC_STAGES` clock edges.
- R3: A cycle with any `out_over` bit at 1 latches the overvoltage fault at that edge. From then on both channels have `chan_en`=0 and `hs_off`=1, and `ls_on`=1 whenever the block is powered (shutdown high, no bias fault).
- R4: `ILIM_RUN` (default 8) consecutive cycles in which a running channel has both `ilim_hit` and `out_low20` at 1 latch the undervoltage fault at the last of those edges. Both channels then get `chan_en`=0 and `hs_off`=1.
- R5: Any cycle without such a hit restarts the run count, so two runs of `ILIM_RUN`-1 hits separated by one idle cycle latch nothing.
- R6: Hits on a channel that is in soft-start or off are not counted.
- R7: A latched fault holds until a synchronized low-then-high sequence on `shdn_n` or on any `ramp_lo` bit, or a cycle with `vin_dip`=1.
- R8: When a latch's set condition and its clear condition fall in the same cycle, the latch ends that cycle set.
- R9: A powered channel that is not enabled drives `ls_on`=1 when its `out_low93` bit is 1 and no overvoltage fault is latched. An enabled channel drives `ls_on`=0.
- R10: With `bias_uv`=1 both channels have `chan_en`=0, `hs_off`=1 and `ls_on`=0.
- R11: During and right after reset, no fault is latched and every channel is off with `hs_off`=1 and `ls_on`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | One edge per switching cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| shdn_n | input | 1 | Shutdown, active low (asynchronous, synchronized inside) |
| bias_uv | input | 1 | Internal bias supply below its undervoltage threshold |
| vin_dip | input | 1 | Input supply has fallen below its restart level |
| ramp_lo | input | NCH | Soft-start ramp above enable level, per channel (asynchronous) |
| ramp_hi | input | NCH | Soft-start ramp above full-run level, per channel (asynchronous) |
| out_over | input | NCH | Output more than 20 % above nominal |
| out_low20 | input | NCH | Output below 20 % of nominal |
| out_low93 | input | NCH | Output below 93 % of nominal |
| ilim_hit | input | NCH | Current limit reached in this cycle |
| chan_en | output | NCH | Channel allowed to switch |
| chan_soft | output | NCH | Channel is in its soft-start phase |
| hs_off | output | NCH | Force the high-side switch off |
| ls_on | output | NCH | Force the low-side switch on |

## Verification
A set condition and a release condition can arrive in the same cycle. This happens when an output stays over its limit while the shutdown input is cycled, or while the input-supply dip flag is pulsed. The bench keeps `out_over` high through each release event and expects the overvoltage latch to stay set (both channels off, low sides on). The same release, once the overvoltage is removed, must clear the latch. The second pair that can coincide is a current-limit hit and a mode change: hits are applied during soft-start, where they must not count, and in run mode, split by one idle cycle, where the count must restart.

// File: rtl/sup_pkg.sv
package sup_pkg;

   typedef enum logic [1:0] {
      CH_OFF  = 2'd0,
      CH_SOFT = 2'd1,
      CH_RUN  = 2'd2
   } ch_mode_e;

   // channel state from power permission and the two ramp levels
   function automatic ch_mode_e decode_mode(input logic pwr, input logic lo, input logic hi);
      if (!pwr || !lo) return CH_OFF;
      if (hi)          return CH_RUN;
      return CH_SOFT;
   endfunction

endpackage

// File: rtl/sup_sync.sv
module sup_sync #(
   parameter int W      = 1,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   localparam int CHAIN = W * STAGES;

   if (W < 1)      begin : g_bad_w  $error("sup_sync: W must be at least 1");      end
   if (STAGES < 1) begin : g_bad_st $error("sup_sync: STAGES must be at least 1"); end

   logic [CHAIN-1:0] chain;

   if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain <= '0;
         else        chain <= d;
      end
   end else begin : g_multi
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain <= '0;
         else        chain <= {chain[CHAIN-W-1:0], d};
      end
   end

   assign q = chain[CHAIN-1 -: W];

endmodule

// File: rtl/sup_rise.sv
module sup_rise #(
   parameter int W = 1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] lvl,
   output logic [W-1:0] rise
);
   if (W < 1) begin : g_bad_w $error("sup_rise: W must be at least 1"); end

   logic [W-1:0] prev;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev <= '0;
      else        prev <= lvl;
   end

   assign rise = lvl & ~prev;

endmodule

// File: rtl/sup_limit_cnt.sv
module sup_limit_cnt #(
   parameter int LIMIT = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic hit,
   output logic trip
);
   localparam int CW = (LIMIT > 2) ? $clog2(LIMIT) : 1;
   localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

   if (LIMIT < 2) begin : g_bad_lim $error("sup_limit_cnt: LIMIT must be at least 2"); end

   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           cnt <= '0;
      else if (!hit)        cnt <= '0;
      else if (cnt != LAST) cnt <= cnt + 1'b1;
   end

   assign trip = hit && (cnt == LAST);

   // R4: the run count never passes the last slot
   a_r4_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= LAST);

   // R5: a cycle without a hit restarts the run
   a_r5_cnt_restart: assert property (@(posedge clk) disable iff (!rst_n)
      !hit |=> (cnt == '0));

endmodule

// File: rtl/sup_fault_latch.sv
module sup_fault_latch (
   input  logic clk,
   input  logic rst_n,
   input  logic set,
   input  logic clr,
   output logic q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   q <= 1'b0;
      else if (set) q <= 1'b1;
      else if (clr) q <= 1'b0;
   end

   // R7: once set, only a release event drops the latch
   a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (q && !clr) |=> q);

   // R8: a set in the same cycle as a release leaves the latch set
   a_r8_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
      set |=> q);

endmodule

// File: rtl/conv_supervisor.sv
module conv_supervisor
   import sup_pkg::*;
#(
   parameter int NCH         = 2,
   parameter int ILIM_RUN    = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           shdn_n,
   input  logic           bias_uv,
   input  logic           vin_dip,
   input  logic [NCH-1:0] ramp_lo,
   input  logic [NCH-1:0] ramp_hi,
   input  logic [NCH-1:0] out_over,
   input  logic [NCH-1:0] out_low20,
   input  logic [NCH-1:0] out_low93,
   input  logic [NCH-1:0] ilim_hit,
   output logic [NCH-1:0] chan_en,
   output logic [NCH-1:0] chan_soft,
   output logic [NCH-1:0] hs_off,
   output logic [NCH-1:0] ls_on
);
   localparam int SW = 1 + 2 * NCH;   // synchronized control bits
   localparam int TW = 1 + NCH;       // bits whose rising edge releases a latch

   if (NCH < 1) begin : g_bad_nch $error("conv_supervisor: NCH must be at least 1"); end

   // ---- control input synchronization
   logic [SW-1:0]  ctl_s;
   logic           shdn_s;
   logic [NCH-1:0] lo_s;
   logic [NCH-1:0] hi_s;

   sup_sync #(.W(SW), .STAGES(SYNC_STAGES)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .d    ({ramp_hi, ramp_lo, shdn_n}),
      .q    (ctl_s)
   );

   assign shdn_s = ctl_s[0];
   assign lo_s   = ctl_s[NCH:1];
   assign hi_s   = ctl_s[SW-1:NCH+1];

   // ---- release detection: low-then-high on shutdown or any ramp enable
   logic [TW-1:0] rel_rise;
   logic          release_ev;

   sup_rise #(.W(TW)) u_rise (
      .clk  (clk),
      .rst_n(rst_n),
      .lvl  ({lo_s, shdn_s}),
      .rise (rel_rise)
   );

   assign release_ev = vin_dip | (|rel_rise);

   // ---- shared fault latches
   logic           ov_q;
   logic           uv_q;
   logic           fault;
   logic           powered;
   logic [NCH-1:0] trip;

   assign fault   = ov_q | uv_q;
   assign powered = shdn_s & ~bias_uv;

   sup_fault_latch u_ov_latch (
      .clk  (clk),
      .rst_n(rst_n),
      .set  (|out_over),
      .clr  (release_ev),
      .q    (ov_q)
   );

   sup_fault_latch u_uv_latch (
      .clk  (clk),
      .rst_n(rst_n),
      .set  (|trip),
      .clr  (release_ev),
      .q    (uv_q)
   );

   // ---- per-channel decode, hit counting and gate forcing
   for (genvar g = 0; g < NCH; g++) begin : g_ch
      ch_mode_e mode;
      logic     hit;

      assign mode = decode_mode(powered, lo_s[g], hi_s[g]);
      assign hit  = ilim_hit[g] & out_low20[g] & (mode == CH_RUN) & ~fault;

      sup_limit_cnt #(.LIMIT(ILIM_RUN)) u_cnt (
         .clk  (clk),
         .rst_n(rst_n),
         .hit  (hit),
         .trip (trip[g])
      );

      assign chan_en[g]   = (mode != CH_OFF) & ~fault;
      assign chan_soft[g] = chan_en[g] & (mode == CH_SOFT);
      assign hs_off[g]    = ~chan_en[g];
      assign ls_on[g]     = powered & (ov_q | (~chan_en[g] & out_low93[g]));

      // R6: a channel in soft-start never produces a trip
      a_r6_soft_no_trip: assert property (@(posedge clk) disable iff (!rst_n)
         chan_soft[g] |-> !trip[g]);
   end

   // R1: synchronized shutdown leaves no channel enabled
   a_r1_shdn_off: assert property (@(posedge clk) disable iff (!rst_n)
      !shdn_s |-> (chan_en == '0 && ls_on == '0));

   // R3: an overvoltage cycle forces every high side off from the next cycle
   a_r3_over_blank: assert property (@(posedge clk) disable iff (!rst_n)
      (|out_over) |=> (&hs_off));

   // R10: a bias undervoltage leaves every gate undriven
   a_r10_bias_off: assert property (@(posedge clk) disable iff (!rst_n)
      bias_uv |-> (chan_en == '0 && ls_on == '0));

endmodule

// File: tb/sim_conv_supervisor.sv
module sim_conv_supervisor;
   localparam int N = 2;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         shdn_n = 1'b0, bias_uv = 1'b0, vin_dip = 1'b0;
   logic [N-1:0] ramp_lo = '0, ramp_hi = '0, out_over = '0;
   logic [N-1:0] out_low20 = '0, out_low93 = '0, ilim_hit = '0;
   logic [N-1:0] chan_en, chan_soft, hs_off, ls_on;

   int checks = 0;
   int errors = 0;

   always #2 clk = ~clk;

   conv_supervisor #(.NCH(N), .ILIM_RUN(8), .SYNC_STAGES(2)) u0 (
      .clk(clk), .rst_n(rst_n), .shdn_n(shdn_n), .bias_uv(bias_uv), .vin_dip(vin_dip),
      .ramp_lo(ramp_lo), .ramp_hi(ramp_hi), .out_over(out_over),
      .out_low20(out_low20), .out_low93(out_low93), .ilim_hit(ilim_hit),
      .chan_en(chan_en), .chan_soft(chan_soft), .hs_off(hs_off), .ls_on(ls_on)
   );

   task automatic chk(input string tag, input string what, input logic [N-1:0] got,
                      input logic [N-1:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s %s got=%b exp=%b t=%0t", tag, what, got, exp, $time);
      end
   endtask

   // expected outputs from the requirements, given latched-fault knowledge
   task automatic expect_all(input string tag, input logic ovf, input logic uvf);
      logic [N-1:0] e_en, e_soft, e_ls;
      logic pwr;
      pwr = shdn_n & ~bias_uv;
      for (int i = 0; i < N; i++) begin
         e_en[i]   = pwr & ramp_lo[i] & ~ovf & ~uvf;
         e_soft[i] = e_en[i] & ~ramp_hi[i];
         e_ls[i]   = pwr & (ovf | (~e_en[i] & out_low93[i]));
      end
      chk(tag, "chan_en", chan_en, e_en);
      chk(tag, "chan_soft", chan_soft, e_soft);
      chk(tag, "hs_off", hs_off, ~e_en);
      chk("R9", "ls_on", ls_on, e_ls);
   endtask

   task automatic settle(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic hits(input int ch, input int n);
      @(negedge clk);
      ilim_hit[ch] = 1'b1;
      repeat (n) @(posedge clk);
      @(negedge clk);
      ilim_hit[ch] = 1'b0;
   endtask

   task automatic finish_run;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   initial begin
      #(4 * 150000);
      errors++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      int seed_sink;
      seed_sink = $urandom(32'h5A17);

      // R11: reset state
      settle(3);
      expect_all("R11", 1'b0, 1'b0);
      @(negedge clk);
      rst_n = 1'b1;
      settle(1);
      expect_all("R11", 1'b0, 1'b0);

      // R2: both channels to full run
      @(negedge clk);
      shdn_n = 1'b1; ramp_lo = 2'b11; ramp_hi = 2'b11;
      settle(4);
      expect_all("R2", 1'b0, 1'b0);

      // constrained random mode decode, no fault stimulus
      for (int k = 0; k < 60; k++) begin
         @(negedge clk);
         shdn_n    = ($urandom % 5) != 0;
         bias_uv   = ($urandom % 6) == 0;
         ramp_lo   = N'($urandom);
         ramp_hi   = N'($urandom);
         out_low93 = N'($urandom);
         ilim_hit  = N'($urandom);
         settle(4);
         if (!shdn_n)     expect_all("R1", 1'b0, 1'b0);
         else if (bias_uv) expect_all("R10", 1'b0, 1'b0);
         else              expect_all("R2", 1'b0, 1'b0);
      end
      @(negedge clk);
      ilim_hit = '0; bias_uv = 1'b0; out_low93 = '0;

      // R1: shutdown overrides ramp flags and 93 % flags
      @(negedge clk);
      shdn_n = 1'b0; ramp_lo = 2'b11; ramp_hi = 2'b11; out_low93 = 2'b11;
      settle(4);
      expect_all("R1", 1'b0, 1'b0);

      // R10: bias undervoltage
      @(negedge clk);
      shdn_n = 1'b1; bias_uv = 1'b1;
      settle(4);
      expect_all("R10", 1'b0, 1'b0);

      // R9: channel 0 off with low output pulls its low side on
      @(negedge clk);
      bias_uv = 1'b0; ramp_lo = 2'b10;
      settle(4);
      chk("R9", "ls_on off-channel", ls_on, 2'b01);
      expect_all("R9", 1'b0, 1'b0);

      // R5: two runs of seven hits split by an idle cycle
      @(negedge clk);
      ramp_lo = 2'b11; out_low93 = 2'b00; out_low20 = 2'b01;
      settle(4);
      hits(0, 7);
      hits(0, 7);
      settle(2);
      chk("R5", "chan_en after split runs", chan_en, 2'b11);

      // R4: eight consecutive hits latch both channels off
      hits(0, 8);
      settle(2);
      chk("R4", "chan_en after 8 hits", chan_en, 2'b00);
      expect_all("R4", 1'b0, 1'b1);
      @(negedge clk);
      out_low93 = 2'b11;
      settle(2);
      expect_all("R9", 1'b0, 1'b1);

      // R7: input dip releases the latch
      @(negedge clk);
      out_low93 = 2'b00; out_low20 = 2'b00; vin_dip = 1'b1;
      @(negedge clk);
      vin_dip = 1'b0;
      settle(2);
      expect_all("R7", 1'b0, 1'b0);

      // R6: hits during soft-start are not counted
      @(negedge clk);
      ramp_hi = 2'b01; out_low20 = 2'b10;
      settle(4);
      hits(1, 20);
      settle(2);
      chk("R6", "chan_en soft hits", chan_en, 2'b11);
      chk("R6", "chan_soft soft hits", chan_soft, 2'b10);

      // R3: one overvoltage cycle latches both channels
      @(negedge clk);
      out_low20 = 2'b00; out_over = 2'b10;
      @(negedge clk);
      out_over = 2'b00;
      settle(1);
      expect_all("R3", 1'b1, 1'b0);
      settle(10);
      expect_all("R7", 1'b1, 1'b0);

      // R7: low-then-high on a ramp enable releases
      @(negedge clk);
      ramp_lo = 2'b10;
      settle(4);
      @(negedge clk);
      ramp_lo = 2'b11;
      settle(5);
      expect_all("R7", 1'b0, 1'b0);

      // R8: release while overvoltage persists leaves latch set
      @(negedge clk);
      out_over = 2'b01;
      settle(2);
      @(negedge clk);
      shdn_n = 1'b0;
      settle(4);
      @(negedge clk);
      shdn_n = 1'b1;
      settle(5);
      expect_all("R8", 1'b1, 1'b0);
      @(negedge clk);
      vin_dip = 1'b1;
      @(negedge clk);
      vin_dip = 1'b0;
      settle(2);
      expect_all("R8", 1'b1, 1'b0);

      // R7: same release once overvoltage is gone clears
      @(negedge clk);
      out_over = 2'b00; vin_dip = 1'b1;
      @(negedge clk);
      vin_dip = 1'b0;
      settle(2);
      expect_all("R7", 1'b0, 1'b0);

      finish_run();
   end

endmodule